// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records the value of a free-running 32-bit time counter at the moment an event occurs. The event comes from one of two places. One is an edge on an asynchronous external request pin, and the edge direction can be chosen. The other is a single-cycle internal trigger pulse from elsewhere in the chip. The captured time stays in a holding register until software has read it and re-armed the unit.

Software works through a four-word register window. The window holds a configuration word, a status word, and the captured time as a low half and a high half. The status word reports the following:
- a valid flag for a held capture;
- an error flag for a missed event;
- the selected source;
- an 8-bit saturating count of detected events.

Software reads the time and then writes the status word back with the valid bit at zero. That write re-arms the unit. An event that arrives while a capture is still held sets the error flag. A configuration bit chooses whether such an event replaces the held time or leaves it alone.

Top module: `evcap_unit`

## Requirements
- R1: After a synchronous reset, all four window words read zero.
- R2: The window addresses are fixed: address 0 is configuration, 1 is status, 2 is captured time bits 15:0, and 3 is captured time bits 31:16. Configuration bits are bit 0 falling-edge select, bit 1 overwrite enable and bit 2 count enable. The other configuration bits read zero.
- R3: When status bit 2 (source) is 1, an internal trigger that is high at a clock edge captures `time_in` at that edge. Valid (status bit 0) reads 1 after that edge, provided no capture was held.
- R4: When the source bit is 0 and configuration bit 0 is 0, a rising edge on `ext_req` is captured. If `ext_req` is first sampled high at clock edge k, the capture takes `time_in` at edge k+2, and valid is still 0 after edge k+1.
- R5: When configuration bit 0 is 1, a falling edge on `ext_req` is captured with the same two-cycle latency, and a rising edge is ignored.
- R6: The source that is not selected has no effect: no capture, no flag change and no count.
- R7: An event while valid is 1 sets the error flag (status bit 1). With overwrite off, the held time is kept.
- R8: With overwrite on, an event while valid is 1 replaces the held time with `time_in` at that edge, sets the error flag, and leaves valid at 1.
- R9: A write to the status word clears valid if bit 0 is written 0 and clears error if bit 1 is written 0. Writing 1 to either bit leaves it unchanged, so software can never set it. The write also loads the source bit from bit 2.
- R10: The event count in status bits 15:8 increases by one on each detected event while count enable is 1. It does not change while count enable is 0. It saturates at 255, and any status write resets it to 0.
- R11: When a status write and an event land on the same edge, the write takes effect first and the event is then applied to the written state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_in | input | 32 | Free-running time counter value |
| ext_req | input | 1 | Asynchronous external event request pin |
| int_trig | input | 1 | Internal single-cycle trigger pulse |
| reg_wr | input | 1 | Register window write strobe |
| reg_addr | input | 2 | Register window word address |
| reg_wdata | input | 16 | Register window write data |
| reg_rdata | output | 16 | Register window read data for `reg_addr` |

## Verification
The bench places the external edge against the two-cycle synchronizer latency. A design with one stage too many or too few would latch a time 13 ticks off, or would raise valid one cycle early. It drives overlapping events with overwrite both off and on: a wrong design would lose the first time, fail to raise the error flag, or drop valid. It also checks three more cases:
- A status write on the same edge as an event, where applying the two in the wrong order leaves valid clear or the count at zero.
- A run of 300 back-to-back events, where a missing saturation wraps the count.
- Edges on the source that is not selected, where a design that fails to block them would report a capture that never happened.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

    // Default geometry of the block.
    localparam int TIME_W_DEF = 32;
    localparam int WORD_W_DEF = 16;
    localparam int SEQ_W_DEF  = 8;
    localparam int SYNC_DEF   = 2;

    // Register window word addresses. The two time halves follow the status word.
    typedef enum logic [1:0] {
        WIN_CFG  = 2'd0,
        WIN_STAT = 2'd1,
        WIN_TLO  = 2'd2,
        WIN_THI  = 2'd3
    } win_addr_e;

    // Configuration word, low bits. The packed order gives bit 2, bit 1, bit 0.
    typedef struct packed {
        logic cnt_en;
        logic ovw_en;
        logic fall_sel;
    } cap_cfg_t;

    // Capture handshake flags.
    typedef struct packed {
        logic err;
        logic valid;
    } cap_flags_t;

    // Status word bit positions.
    localparam int ST_VALID = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_SRC   = 2;

    // Edge match on two successive synchronized samples.
    function automatic logic edge_seen(input logic now_s, input logic prev_s, input logic fall);
        return fall ? (prev_s & ~now_s) : (now_s & ~prev_s);
    endfunction

endpackage

// File: rtl/evcap_edge_sync.sv
module evcap_edge_sync #(
    parameter int STAGES = evcap_pkg::SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_o
);
    import evcap_pkg::*;

    // STAGES synchronizer flops plus one history flop for the edge compare.
    localparam int LAST = STAGES;

    logic [LAST:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[LAST-1:0], pin};
    end

    assign edge_o = edge_seen(sync_q[LAST-1], sync_q[LAST], fall_sel);

endmodule

// File: rtl/evcap_core.sv
module evcap_core #(
    parameter int TIME_W = evcap_pkg::TIME_W_DEF,
    parameter int SEQ_W  = evcap_pkg::SEQ_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [TIME_W-1:0] time_in,
    input  logic              ovw_en,
    input  logic              cnt_en,
    input  logic              stat_wr,
    input  logic              keep_valid,
    input  logic              keep_err,
    output logic              valid_o,
    output logic              err_o,
    output logic [TIME_W-1:0] cap_o,
    output logic [SEQ_W-1:0]  seq_o
);
    import evcap_pkg::*;

    localparam logic [SEQ_W-1:0] SEQ_MAX = '1;

    cap_flags_t        flags_q, flags_w, flags_n;
    logic [TIME_W-1:0] cap_q, cap_n;
    logic [SEQ_W-1:0]  seq_q, seq_w, seq_n;

    always_comb begin
        // The software write is applied first.
        flags_w = flags_q;
        seq_w   = seq_q;
        if (stat_wr) begin
            flags_w.valid = flags_q.valid & keep_valid;
            flags_w.err   = flags_q.err & keep_err;
            seq_w         = '0;
        end
        // The event is then applied to the written state.
        flags_n = flags_w;
        cap_n   = cap_q;
        seq_n   = seq_w;
        if (hit) begin
            if (flags_w.valid) begin
                flags_n.err = 1'b1;
                if (ovw_en) cap_n = time_in;
            end else begin
                flags_n.valid = 1'b1;
                cap_n         = time_in;
            end
            if (cnt_en && (seq_w != SEQ_MAX)) seq_n = seq_w + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            cap_q   <= '0;
            seq_q   <= '0;
        end else begin
            flags_q <= flags_n;
            cap_q   <= cap_n;
            seq_q   <= seq_n;
        end
    end

    assign valid_o = flags_q.valid;
    assign err_o   = flags_q.err;
    assign cap_o   = cap_q;
    assign seq_o   = seq_q;

endmodule

// File: rtl/evcap_unit.sv
module evcap_unit #(
    parameter int TIME_W      = evcap_pkg::TIME_W_DEF,
    parameter int WORD_W      = evcap_pkg::WORD_W_DEF,
    parameter int SEQ_W       = evcap_pkg::SEQ_W_DEF,
    parameter int SYNC_STAGES = evcap_pkg::SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] time_in,
    input  logic              ext_req,
    input  logic              int_trig,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    import evcap_pkg::*;

    localparam int CFG_W = $bits(cap_cfg_t);

    cap_cfg_t          cfg_q;
    logic              src_int_q;
    logic              ext_edge;
    logic              evt_hit;
    logic              wr_stat;
    logic              wr_cfg;
    logic              cap_valid;
    logic              cap_err;
    logic [TIME_W-1:0] cap_time;
    logic [SEQ_W-1:0]  seq_cnt;
    logic [WORD_W-1:0] stat_word;

    assign wr_cfg  = reg_wr && (win_addr_e'(reg_addr) == WIN_CFG);
    assign wr_stat = reg_wr && (win_addr_e'(reg_addr) == WIN_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            src_int_q <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q     <= cap_cfg_t'(reg_wdata[CFG_W-1:0]);
            if (wr_stat) src_int_q <= reg_wdata[ST_SRC];
        end
    end

    evcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_req),
        .fall_sel (cfg_q.fall_sel),
        .edge_o   (ext_edge)
    );

    assign evt_hit = src_int_q ? int_trig : ext_edge;

    evcap_core #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .hit        (evt_hit),
        .time_in    (time_in),
        .ovw_en     (cfg_q.ovw_en),
        .cnt_en     (cfg_q.cnt_en),
        .stat_wr    (wr_stat),
        .keep_valid (reg_wdata[ST_VALID]),
        .keep_err   (reg_wdata[ST_ERR]),
        .valid_o    (cap_valid),
        .err_o      (cap_err),
        .cap_o      (cap_time),
        .seq_o      (seq_cnt)
    );

    always_comb begin
        stat_word                     = '0;
        stat_word[ST_VALID]           = cap_valid;
        stat_word[ST_ERR]             = cap_err;
        stat_word[ST_SRC]             = src_int_q;
        stat_word[WORD_W-1 -: SEQ_W]  = seq_cnt;
    end

    always_comb begin
        case (win_addr_e'(reg_addr))
            WIN_CFG:  reg_rdata = WORD_W'(cfg_q);
            WIN_STAT: reg_rdata = stat_word;
            WIN_TLO:  reg_rdata = cap_time[WORD_W-1:0];
            default:  reg_rdata = WORD_W'(cap_time >> WORD_W);
        endcase
    end

endmodule

// File: rtl/evcap_unit_chk.sv
module evcap_unit_chk #(
    parameter int TIME_W = 32,
    parameter int SEQ_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              hit,
    input logic              wr_stat,
    input logic              ovw_en,
    input logic              valid,
    input logic              err,
    input logic [TIME_W-1:0] cap,
    input logic [SEQ_W-1:0]  seq
);
    // R3: the held time changes only on an event edge.
    a_r3_cap_only_on_event: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cap));

    // R7: an overlapping event with overwrite off keeps the first time.
    a_r7_keep_first: assert property (@(posedge clk) disable iff (rst)
        (valid && hit && !ovw_en && !wr_stat) |=> $stable(cap));

    // R7: an overlapping event raises the error flag.
    a_r7_err_on_overlap: assert property (@(posedge clk) disable iff (rst)
        (valid && hit && !wr_stat) |=> err);

    // R8: an overwrite leaves the valid flag set.
    a_r8_valid_kept: assert property (@(posedge clk) disable iff (rst)
        (valid && hit && ovw_en && !wr_stat) |=> valid);

    // R9: only an event can set the valid flag.
    a_r9_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        (!valid && !hit) |=> !valid);

    // R10: the count holds at its maximum.
    a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
        ((&seq) && !wr_stat) |=> (&seq));

    // R10: the count moves by at most one per cycle.
    a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((seq == $past(seq)) || (seq == $past(seq) + 1'b1)));

    // R10: a status write without an event clears the count.
    a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !hit) |=> (seq == '0));
endmodule

bind evcap_unit evcap_unit_chk #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .hit     (evt_hit),
    .wr_stat (wr_stat),
    .ovw_en  (cfg_q.ovw_en),
    .valid   (cap_valid),
    .err     (cap_err),
    .cap     (cap_time),
    .seq     (seq_cnt)
);

// File: tb/evcap_unit_test.sv
module evcap_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] time_in = 32'hFFFF_FF40;
    logic        ext_req = 1'b0;
    logic        int_trig = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) time_in <= time_in + 32'd13;

    evcap_unit uut (
        .clk       (clk),
        .rst       (rst),
        .time_in   (time_in),
        .ext_req   (ext_req),
        .int_trig  (int_trig),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // Behavioural reference model.
    bit [2:0]  m_cfg;
    bit        m_src, m_valid, m_err;
    int        m_seq;
    bit [31:0] m_cap;
    bit        ehist[$] = '{1'b0, 1'b0, 1'b0};

    always @(posedge clk) begin
        bit hit, v, e, wst;
        int s;
        if (rst) begin
            m_cfg = 0; m_src = 0; m_valid = 0; m_err = 0; m_seq = 0; m_cap = 0;
            ehist = '{1'b0, 1'b0, 1'b0};
        end else begin
            wst = reg_wr && (reg_addr == 2'd1);
            if (m_src)         hit = int_trig;
            else if (m_cfg[0]) hit = !ehist[1] && ehist[2];
            else               hit = ehist[1] && !ehist[2];
            v = wst ? (m_valid && reg_wdata[0]) : m_valid;
            e = wst ? (m_err && reg_wdata[1]) : m_err;
            s = wst ? 0 : m_seq;
            if (hit) begin
                if (v) begin
                    e = 1;
                    if (m_cfg[1]) m_cap = time_in;
                end else begin
                    v = 1;
                    m_cap = time_in;
                end
                if (m_cfg[2] && s < 255) s++;
            end
            m_valid = v; m_err = e; m_seq = s;
            if (wst) m_src = reg_wdata[2];
            if (reg_wr && reg_addr == 2'd0) m_cfg = reg_wdata[2:0];
            ehist.push_front(ext_req);
            void'(ehist.pop_back());
        end
    end

    function automatic logic [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {13'd0, m_cfg};
            2'd1:    return {m_seq[7:0], 5'd0, m_src, m_err, m_valid};
            2'd2:    return m_cap[15:0];
            default: return m_cap[31:16];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) chk("R2 per-cycle window vs model", {16'd0, reg_rdata}, {16'd0, m_read(reg_addr)});
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(tag, {16'd0, v}, {16'd0, exp});
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic expect_cap(input string tag, input logic [31:0] exp);
        expect_reg(tag, 2'd2, exp[15:0]);
        expect_reg(tag, 2'd3, exp[31:16]);
    endtask

    task automatic pulse(output logic [31:0] t);
        t = time_in;
        int_trig = 1'b1;
        tick();
        int_trig = 1'b0;
    endtask

    initial begin
        logic [31:0] t1, t2, t3;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        expect_reg("R1 cfg after reset", 2'd0, 16'h0000);
        expect_reg("R1 status after reset", 2'd1, 16'h0000);
        expect_reg("R1 time lo after reset", 2'd2, 16'h0000);
        expect_reg("R1 time hi after reset", 2'd3, 16'h0000);

        // R2: config readback, upper bits read zero
        wr(2'd0, 16'hFFFB);
        expect_reg("R2 cfg readback masked", 2'd0, 16'h0003);
        wr(2'd0, 16'h0004);
        expect_reg("R2 cfg readback", 2'd0, 16'h0004);
        wr(2'd1, 16'h0004);
        expect_reg("R9 source loaded", 2'd1, 16'h0004);

        // R3: internal capture
        pulse(t1);
        expect_cap("R3 internal capture time", t1);
        expect_reg("R3 status after capture", 2'd1, 16'h0105);

        // R7: overlap, overwrite off
        pulse(t2);
        expect_cap("R7 first time kept", t1);
        expect_reg("R7 error raised", 2'd1, 16'h0207);

        // R9: clear semantics
        wr(2'd1, 16'h0006);
        expect_reg("R9 valid cleared, error kept", 2'd1, 16'h0006);
        wr(2'd1, 16'h0005);
        expect_reg("R9 valid not settable, error cleared", 2'd1, 16'h0004);
        pulse(t3);
        expect_cap("R9 re-armed capture", t3);

        // R8: overwrite on
        wr(2'd1, 16'h0004);
        wr(2'd0, 16'h0006);
        t1 = time_in;
        int_trig = 1'b1;
        tick();
        t2 = time_in;
        tick();
        int_trig = 1'b0;
        expect_cap("R8 second time replaces first", t2);
        expect_reg("R8 valid and error set", 2'd1, 16'h0207);

        // R6: internal trigger ignored while external selected
        wr(2'd1, 16'h0000);
        pulse(t3);
        tick(); tick();
        expect_reg("R6 internal ignored", 2'd1, 16'h0000);

        // R4: rising external edge with two-cycle latency
        wr(2'd0, 16'h0004);
        ext_req = 1'b1;
        tick();
        tick();
        expect_reg("R4 not yet captured", 2'd1, 16'h0000);
        t1 = time_in;
        tick();
        expect_cap("R4 external capture time", t1);
        expect_reg("R4 status after capture", 2'd1, 16'h0101);

        // R6: external edges ignored while internal selected
        wr(2'd1, 16'h0004);
        ext_req = 1'b0; tick(); tick();
        ext_req = 1'b1; tick(); tick();
        ext_req = 1'b0; repeat (4) tick();
        expect_reg("R6 external ignored", 2'd1, 16'h0004);

        // R5: falling edge select
        wr(2'd0, 16'h0005);
        wr(2'd1, 16'h0000);
        ext_req = 1'b1;
        repeat (4) tick();
        expect_reg("R5 rising ignored", 2'd1, 16'h0000);
        ext_req = 1'b0;
        tick();
        tick();
        t2 = time_in;
        tick();
        expect_cap("R5 falling capture time", t2);
        expect_reg("R5 status after capture", 2'd1, 16'h0101);

        // R11: write and event on the same edge
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'h0004);
        pulse(t1);
        expect_reg("R11 setup valid", 2'd1, 16'h0105);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0004;
        int_trig = 1'b1;
        t3 = time_in;
        tick();
        reg_wr = 1'b0; int_trig = 1'b0;
        expect_reg("R11 write then event", 2'd1, 16'h0105);
        expect_cap("R11 fresh capture time", t3);

        // R10: count enable, saturation, clear
        wr(2'd1, 16'h0004);
        wr(2'd0, 16'h0000);
        pulse(t1);
        expect_reg("R10 no count when disabled", 2'd1, 16'h0005);
        wr(2'd0, 16'h0004);
        int_trig = 1'b1;
        repeat (300) tick();
        int_trig = 1'b0;
        expect_reg("R10 saturates at 255", 2'd1, 16'hFF07);
        wr(2'd1, 16'h0007);
        expect_reg("R10 status write clears count", 2'd1, 16'h0007);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog act=timeout exp=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule